// File: doc/BRIEF.md
# Flash Write-Status Poll Bit Generator

This block sits in the read path of a NOR-style flash device and decides what the most significant data bit shows while an internal program or erase operation runs. The command decoder hands it a one-cycle start pulse for each accepted program or erase command. With each pulse come the target address, the top bit of the byte being programmed, and the sector-select and sector-protect flags. The cell engine reports whether a program or an erase is still running, and whether the erase is suspended. The host polls the top bit to learn when the operation has finished. The lower bits always come from the array.

While a program runs, a read at the program address returns the inverse of the target top bit. Once the program ends, the array's true value shows through. While an erase runs, reads inside a sector chosen for erasure return a zero top bit, and this changes to one while the erase is suspended. A program issued during suspend behaves like any other program, and it takes priority at its own address.

Some commands target only protected sectors: a program into a protected sector, or an erase whose selected sectors are all protected. For these the block creates a fake busy window of a fixed number of microsecond ticks, and then returns to plain array data. An erase where only part of the selection is protected covers only the unprotected sectors. A ready/busy output is low whenever any of this work is in progress.

Top module: `flash_poll_status`

## Requirements
- R1: While `oe_n` is high, `dout` is all zeros.
- R2: With `oe_n` low and no status hit, `dout` equals `arr_data` on every bit.
- R3: While a program is in progress (`pgm_active` high), a read at the latched program address returns the inverse of the latched `pgm_msb` on bit DW-1 and `arr_data` on the lower bits.
- R4: Once `pgm_active` falls after an unprotected program, a read at the program address returns `arr_data` unchanged, so bit DW-1 shows the true programmed value.
- R5: While an erase is in progress, a read whose sector field (address bits AW-1 down to AW-SW) selects an erase target sector returns 0 on bit DW-1, or 1 while `ers_susp` is high.
- R6: During an erase suspend, a program's status at its own address takes priority over the erase status of that sector.
- R7: A `pgm_go` whose address lies in a protected sector opens a window lasting exactly SHORT_TICKS `us_tick` pulses. During the window, bit DW-1 at that address is the inverse of `pgm_msb` and `ry_by_n` is low. After the window, reads return array data.
- R8: An `ers_go` where `sect_sel` is non-zero and every selected sector is protected opens a window lasting exactly LONG_TICKS ticks. During it, reads in the selected sectors return 0 on bit DW-1 and `ry_by_n` is low. After it, reads return array data.
- R9: When only part of the selection is protected, reads in the protected selected sectors return array data, and reads in the unprotected selected sectors return erase status.
- R10: `ry_by_n` is low exactly when any of these holds: a program is active, either window is open, or an erase is active and not suspended.
- R11: After reset, no window is open, `ry_by_n` is high and reads return array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| pgm_go | input | 1 | Program command accepted (final write strobe) |
| pgm_addr | input | AW | Program target address, latched on `pgm_go` |
| pgm_msb | input | 1 | Top bit of the byte being programmed |
| pgm_active | input | 1 | Cell engine is programming |
| ers_go | input | 1 | Erase command accepted |
| ers_active | input | 1 | Cell engine is erasing |
| ers_susp | input | 1 | Erase is suspended |
| sect_sel | input | 2**SW | Sectors chosen for erase, latched on `ers_go` |
| sect_prot | input | 2**SW | Per-sector protection flags |
| oe_n | input | 1 | Active-low output enable |
| rd_addr | input | AW | Read address |
| arr_data | input | DW | Array read data |
| dout | output | DW | Data returned to the host |
| ry_by_n | output | 1 | High when ready, low when busy |

## Verification
A wrong latched address or erase mask affects only reads in the sector or at the address involved. It shows up on the same read cycle as a top bit that is inverted or missing, so random reads are weighted toward the target addresses. A window counter that is off by one shows up on the tick after the expected end, as `ry_by_n` stuck low or status still showing. A window that closes early shows up on the tick before the end. A mistake in the suspend or priority logic shows as the wrong top bit on the first read at the program address during suspend.

// File: rtl/fps_pkg.sv
package fps_pkg;

  // Top-bit selection: program status beats erase status beats array data.
  function automatic logic poll_msb(input logic pgm_hit, input logic ers_hit,
                                    input logic susp, input logic tgt_msb,
                                    input logic arr_msb);
    if (pgm_hit)      return ~tgt_msb;
    else if (ers_hit) return susp;
    else              return arr_msb;
  endfunction

  // Busy whenever real or fake work is in progress; a suspended erase is idle.
  function automatic logic busy_of(input logic pgm_act, input logic ers_act,
                                   input logic susp, input logic swin,
                                   input logic lwin);
    return pgm_act | swin | lwin | (ers_act & ~susp);
  endfunction

endpackage

// File: rtl/fps_win_timer.sv
module fps_win_timer #(
  parameter int LEN = 2,
  localparam int CW = $clog2(LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic active
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (start)             cnt <= CW'(LEN);
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/fps_target_reg.sv
module fps_target_reg #(
  parameter int AW = 12,
  parameter int SW = 3,
  parameter int NSECT = 1 << SW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pgm_go,
  input  logic [AW-1:0]    pgm_addr,
  input  logic             pgm_msb,
  input  logic             ers_go,
  input  logic [NSECT-1:0] sect_sel,
  input  logic [NSECT-1:0] sect_prot,
  output logic [AW-1:0]    pgm_addr_q,
  output logic             pgm_msb_q,
  output logic [NSECT-1:0] ers_mask_q,
  output logic             pgm_prot_go,
  output logic             ers_allprot_go
);
  logic [SW-1:0]    pgm_sect;
  logic [NSECT-1:0] live_sel;

  assign pgm_sect       = pgm_addr[AW-1 -: SW];
  assign live_sel       = sect_sel & ~sect_prot;
  assign pgm_prot_go    = pgm_go & sect_prot[pgm_sect];
  assign ers_allprot_go = ers_go & (|sect_sel) & ~(|live_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pgm_addr_q <= '0;
      pgm_msb_q  <= 1'b0;
      ers_mask_q <= '0;
    end else begin
      if (pgm_go) begin
        pgm_addr_q <= pgm_addr;
        pgm_msb_q  <= pgm_msb;
      end
      // All-protected erase keeps the whole selection as the status region.
      if (ers_go) ers_mask_q <= (live_sel == '0) ? sect_sel : live_sel;
    end
  end
endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status #(
  parameter int AW = 12,
  parameter int SW = 3,
  parameter int DW = 8,
  parameter int SHORT_TICKS = 2,
  parameter int LONG_TICKS = 100,
  localparam int NSECT = 1 << SW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic             pgm_go,
  input  logic [AW-1:0]    pgm_addr,
  input  logic             pgm_msb,
  input  logic             pgm_active,
  input  logic             ers_go,
  input  logic             ers_active,
  input  logic             ers_susp,
  input  logic [NSECT-1:0] sect_sel,
  input  logic [NSECT-1:0] sect_prot,
  input  logic             oe_n,
  input  logic [AW-1:0]    rd_addr,
  input  logic [DW-1:0]    arr_data,
  output logic [DW-1:0]    dout,
  output logic             ry_by_n
);
  import fps_pkg::*;

  logic [AW-1:0]    tgt_addr;
  logic             tgt_msb;
  logic [NSECT-1:0] ers_mask;
  logic             pgm_prot_go, ers_allprot_go;
  logic             short_win, long_win;
  logic             pgm_hit, ers_hit;
  logic             msb_out;

  fps_target_reg #(.AW(AW), .SW(SW), .NSECT(NSECT)) u_tgt (
    .clk(clk), .rst_n(rst_n),
    .pgm_go(pgm_go), .pgm_addr(pgm_addr), .pgm_msb(pgm_msb),
    .ers_go(ers_go), .sect_sel(sect_sel), .sect_prot(sect_prot),
    .pgm_addr_q(tgt_addr), .pgm_msb_q(tgt_msb), .ers_mask_q(ers_mask),
    .pgm_prot_go(pgm_prot_go), .ers_allprot_go(ers_allprot_go)
  );

  fps_win_timer #(.LEN(SHORT_TICKS)) u_short (
    .clk(clk), .rst_n(rst_n), .start(pgm_prot_go), .tick(us_tick),
    .active(short_win)
  );

  fps_win_timer #(.LEN(LONG_TICKS)) u_long (
    .clk(clk), .rst_n(rst_n), .start(ers_allprot_go), .tick(us_tick),
    .active(long_win)
  );

  // Named hit events, brought out for the checker.
  assign pgm_hit = (pgm_active | short_win) & (rd_addr == tgt_addr);
  assign ers_hit = (ers_active | long_win) & ers_mask[rd_addr[AW-1 -: SW]];

  assign msb_out = poll_msb(pgm_hit, ers_hit, ers_susp, tgt_msb, arr_data[DW-1]);
  assign dout    = oe_n ? '0 : {msb_out, arr_data[DW-2:0]};
  assign ry_by_n = ~busy_of(pgm_active, ers_active, ers_susp, short_win, long_win);
endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          us_tick,
  input logic          oe_n,
  input logic          pgm_active,
  input logic          ers_susp,
  input logic          short_win,
  input logic          long_win,
  input logic          pgm_hit,
  input logic          ers_hit,
  input logic          tgt_msb,
  input logic [DW-1:0] arr_data,
  input logic [DW-1:0] dout,
  input logic          ry_by_n
);
  a_r1_released_zero: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> dout == '0);

  a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && !pgm_hit && !ers_hit) |-> dout == arr_data);

  a_r3_pgm_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && pgm_hit) |-> (dout[DW-1] != tgt_msb && dout[DW-2:0] == arr_data[DW-2:0]));

  a_r5_erase_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && ers_hit && !pgm_hit) |-> dout[DW-1] == ers_susp);

  a_r7_short_ends_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(short_win) |-> $past(us_tick));

  a_r8_long_ends_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(long_win) |-> $past(us_tick));

  a_r10_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_active || short_win || long_win) |-> !ry_by_n);
endmodule

bind flash_poll_status fps_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .oe_n(oe_n),
  .pgm_active(pgm_active), .ers_susp(ers_susp),
  .short_win(short_win), .long_win(long_win),
  .pgm_hit(pgm_hit), .ers_hit(ers_hit), .tgt_msb(tgt_msb),
  .arr_data(arr_data), .dout(dout), .ry_by_n(ry_by_n)
);

// File: tb/sim_flash_poll_status.sv
module sim_flash_poll_status;
  localparam int AW = 12, SW = 3, DW = 8, NS = 8;
  localparam int SHORT = 2, LONG = 100;

  logic clk = 0, rst_n = 0, us_tick = 0;
  logic pgm_go = 0, pgm_msb = 0, pgm_active = 0;
  logic ers_go = 0, ers_active = 0, ers_susp = 0;
  logic [AW-1:0] pgm_addr = '0, rd_addr = '0;
  logic [NS-1:0] sect_sel = '0, sect_prot = '0;
  logic oe_n = 1;
  logic [DW-1:0] arr_data = '0;
  logic [DW-1:0] dout;
  logic ry_by_n;

  int checks = 0, errors = 0;
  bit done = 0;

  // Bench model state
  logic m_pact = 0, m_swin = 0, m_eact = 0, m_lwin = 0, m_susp = 0, m_pmsb = 0;
  logic [AW-1:0] m_paddr = '0;
  logic [NS-1:0] m_mask = '0;

  always #5 clk = ~clk;

  flash_poll_status #(.AW(AW), .SW(SW), .DW(DW), .SHORT_TICKS(SHORT),
                      .LONG_TICKS(LONG)) u0 (.*);

  function automatic logic [DW-1:0] exp_dout(logic [AW-1:0] a, logic [DW-1:0] d, logic oe);
    if (oe) return '0;
    if ((m_pact || m_swin) && a == m_paddr) return {~m_pmsb, d[DW-2:0]};
    if ((m_eact || m_lwin) && m_mask[a[AW-1:AW-SW]]) return {m_susp, d[DW-2:0]};
    return d;
  endfunction

  function automatic logic exp_ry();
    return !(m_pact || m_swin || m_lwin || (m_eact && !m_susp));
  endfunction

  task automatic chk(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      us_tick = 1; cyc(); us_tick = 0; cyc();
    end
  endtask

  // Random reads, one in three aimed at the focus address.
  task automatic reads(int n, string tag, logic [AW-1:0] focus);
    for (int i = 0; i < n; i++) begin
      rd_addr  = ($urandom % 3 == 0) ? focus : AW'($urandom);
      arr_data = DW'($urandom);
      oe_n     = ($urandom % 8 == 0);
      #1;
      chk(tag, dout, exp_dout(rd_addr, arr_data, oe_n));
      chk({tag, " R10 busy"}, {7'd0, ry_by_n}, {7'd0, exp_ry()});
      @(negedge clk);
    end
  endtask

  task automatic read_at(string tag, logic [AW-1:0] a, logic [DW-1:0] d);
    rd_addr = a; arr_data = d; oe_n = 0; #1;
    chk(tag, dout, exp_dout(a, d, 0));
    @(negedge clk);
  endtask

  task automatic start_pgm(logic [AW-1:0] a, logic msb, logic prot);
    pgm_addr = a; pgm_msb = msb; pgm_go = 1;
    pgm_active = !prot;
    cyc(); pgm_go = 0;
    m_paddr = a; m_pmsb = msb; m_pact = !prot; m_swin = prot;
  endtask

  task automatic start_ers(logic [NS-1:0] sel, logic [NS-1:0] prot);
    logic [NS-1:0] live;
    live = sel & ~prot;
    sect_sel = sel; sect_prot = prot; ers_go = 1;
    ers_active = (live != '0);
    cyc(); ers_go = 0;
    m_mask = (live == '0) ? sel : live;
    m_eact = (live != '0); m_lwin = (sel != '0) && (live == '0);
  endtask

  task automatic finish_report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung expected finish");
      finish_report();
    end
  end

  initial begin
    logic [AW-1:0] a;
    logic [DW-1:0] b;
    void'($urandom(32'd4711));
    repeat (3) cyc();
    rst_n = 1; cyc();

    // R11 reset state, R1, R2
    oe_n = 0; #1;
    chk("R11 ready after reset", {7'd0, ry_by_n}, 8'd1);
    @(negedge clk);
    read_at("R11 array after reset", 12'h2A5, 8'hC3);
    oe_n = 1; #1; chk("R1 released", dout, 8'h00); @(negedge clk);
    reads(30, "R2 idle", 12'h000);

    // R3 program running, R4 finished
    a = {3'd5, 9'($urandom)}; b = DW'($urandom);
    start_pgm(a, b[7], 0);
    read_at("R3 complement at target", a, b);
    reads(40, "R3 program", a);
    pgm_active = 0; m_pact = 0;
    read_at("R4 true data", a, b);
    reads(10, "R4 after program", a);

    // R5 erase, suspend, R6 program in suspend
    start_ers(8'b0110_0010, 8'h00);
    read_at("R5 erase zero", {3'd6, 9'h011}, 8'hFF);
    reads(30, "R5 erase", {3'd1, 9'h0F0});
    ers_susp = 1; m_susp = 1; cyc();
    read_at("R5 suspend one", {3'd5, 9'h011}, 8'h00);
    chk("R10 ready in suspend", {7'd0, ry_by_n}, 8'd1);
    a = {3'd5, 9'h123};
    start_pgm(a, 1'b0, 0);
    read_at("R6 program priority", a, 8'h00);
    read_at("R6 other addr in sector", {3'd5, 9'h124}, 8'h00);
    reads(30, "R6 suspend program", a);
    pgm_active = 0; m_pact = 0;
    ers_susp = 0; m_susp = 0; cyc();
    reads(10, "R5 resumed", {3'd6, 9'h000});
    ers_active = 0; m_eact = 0; cyc();
    reads(10, "R5 erase done", {3'd6, 9'h000});

    // R7 protected program window
    sect_prot = 8'b0000_1000;
    a = {3'd3, 9'h1A7};
    start_pgm(a, 1'b1, 1);
    read_at("R7 window status", a, 8'hFF);
    chk("R7 busy", {7'd0, ry_by_n}, 8'd0);
    ticks(SHORT - 1);
    read_at("R7 still open before last tick", a, 8'hFF);
    ticks(1); m_swin = 0;
    read_at("R7 array after window", a, 8'hFF);
    chk("R7 ready after window", {7'd0, ry_by_n}, 8'd1);

    // R8 all-protected erase window
    start_ers(8'b1001_0000, 8'b1101_0000);
    read_at("R8 window zero", {3'd7, 9'h055}, 8'hFF);
    reads(20, "R8 window", {3'd4, 9'h001});
    ticks(LONG - 1);
    read_at("R8 open before last tick", {3'd4, 9'h001}, 8'hFF);
    chk("R8 busy", {7'd0, ry_by_n}, 8'd0);
    ticks(1); m_lwin = 0;
    read_at("R8 array after window", {3'd7, 9'h055}, 8'hFF);
    chk("R8 ready after window", {7'd0, ry_by_n}, 8'd1);

    // R9 partial protection
    start_ers(8'b0000_1111, 8'b0000_0101);
    read_at("R9 protected sector array", {3'd0, 9'h010}, 8'hFF);
    read_at("R9 unprotected sector status", {3'd1, 9'h010}, 8'hFF);
    reads(40, "R9 partial", {3'd2, 9'h000});
    ers_active = 0; m_eact = 0; cyc();
    chk("R10 idle after erase", {7'd0, ry_by_n}, 8'd1);

    done = 1;
    finish_report();
  end
endmodule